// File: doc/BRIEF.md
# Dual-Channel DAC Sample Unpacker

This block sits between an output DMA stream and two DAC sample pipes. Each of the two channels receives 32-bit words on its own valid/ready input. It splits each word into the samples its DAC consumes. In 16-bit operation a word carries two samples, and in 20-bit operation it carries one. Each sample leaves on a valid/ready output as a 20-bit value, together with a tag that shows which width produced it.

A single control register in a small memory-mapped space sets up both channels. For each channel it holds an enable bit and a width-select bit. Software can switch a channel's width while words are still moving. The new width is applied only to words that arrive after the change. A word that is already held finishes with the width it was accepted under. Clearing a channel's enable stops that channel at once and discards any partly used word it holds.

Top module: `dac_unpack_top`

## Requirements
- R1: After reset, both channels are disabled and set to 20-bit operation. The control register reads 0, every in_ready bit is 0 and every out_valid bit is 0.
- R2: The control register sits at byte address 0x40080. For channel c, bit 2c is the enable and bit 2c+1 selects 16-bit operation when set. Its other bits read 0. A read at any other address returns 0, and a write to any other address changes nothing.
- R3: In 20-bit operation, each accepted word produces exactly one sample. The sample data is bits 19:0 of the word and out_wide is 1. Bits 31:20 of the word have no effect.
- R4: In 16-bit operation, each accepted word produces two samples with out_wide 0. Bits 15:0 of the word come out first, then bits 31:16.
- R5: A 16-bit sample is left-aligned in the 20-bit output as {halfword, 4'b0000}.
- R6: While a channel is disabled, its in_ready and out_valid are both 0.
- R7: Disabling a channel discards the word it holds. After it is enabled again, its first sample comes from a newly accepted word.
- R8: A width change applies only from the next accepted word on. The samples of a held word keep the width in force when that word was accepted.
- R9: While out_valid is 1 and out_ready is 0, the sample and its tag stay unchanged in the next cycle, unless the channel has been disabled.
- R10: The two channels run independently. Each has its own width, enable and handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 20 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| in_valid | input | 2 | Per-channel input word valid |
| in_data | input | 64 | Per-channel input words, channel c at bits 32c+31:32c |
| in_ready | output | 2 | Per-channel input word ready |
| out_valid | output | 2 | Per-channel sample valid |
| out_data | output | 40 | Per-channel samples, channel c at bits 20c+19:20c |
| out_wide | output | 2 | Per-channel tag: 1 = 20-bit sample, 0 = 16-bit sample |
| out_ready | input | 2 | Per-channel sample ready |

## Verification
The assertions make no assumption about the stream inputs. in_valid, in_data and out_ready may change on any cycle. The hold property allows a presented sample to be withdrawn only when the channel is disabled. The bench therefore changes the width select and the enable at arbitrary points, including while a word is half consumed. It draws valid and ready from $urandom at set rates. Every input, register write included, changes only at the falling edge, and reset is held for several cycles before the first write.

// File: rtl/dac_unpack_pkg.sv
package dac_unpack_pkg;
    localparam int WORD_W   = 32;
    localparam int SAMPLE_W = 20;
    localparam int HALF_W   = 16;

    typedef struct packed {
        logic              have;
        logic              wide;
        logic              upper;
        logic [WORD_W-1:0] word;
    } lane_state_t;
endpackage

// File: rtl/dac_ctl_regs.sv
module dac_ctl_regs #(
    parameter int          NUM_CH    = 2,
    parameter int          AW        = 20,
    parameter int          DW        = 32,
    parameter logic [19:0] CTRL_ADDR = 20'h40080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] ch_narrow
);
    localparam int CW = 2 * NUM_CH;

    logic [CW-1:0] ctrl_d, ctrl_q;
    logic          hit;

    always_comb begin
        hit    = (reg_addr == CTRL_ADDR[AW-1:0]);
        ctrl_d = ctrl_q;
        if (reg_we && hit) begin
            ctrl_d = reg_wdata[CW-1:0];
        end
        reg_rdata = '0;
        if (hit) begin
            reg_rdata[CW-1:0] = ctrl_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
        assign ch_en[c]     = ctrl_q[2*c];
        assign ch_narrow[c] = ctrl_q[2*c+1];
    end

    // R2: writes elsewhere in the map leave the control state untouched
    p_foreign_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !hit) |=> $stable(ctrl_q));
endmodule

// File: rtl/dac_lane.sv
module dac_lane
    import dac_unpack_pkg::*;
#(
    parameter int W_WORD   = WORD_W,
    parameter int W_SAMPLE = SAMPLE_W,
    parameter int W_HALF   = HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                narrow,
    input  logic                in_valid,
    input  logic [W_WORD-1:0]   in_data,
    output logic                in_ready,
    output logic                out_valid,
    output logic [W_SAMPLE-1:0] out_data,
    output logic                out_wide,
    input  logic                out_ready
);
    localparam int PAD = W_SAMPLE - W_HALF;

    lane_state_t st_d, st_q;
    logic        last_piece;
    logic        take;
    logic [W_HALF-1:0] half;

    always_comb begin
        last_piece = st_q.wide || st_q.upper;
        in_ready   = en && (!st_q.have || (out_ready && last_piece));
        take       = in_valid && in_ready;
        out_valid  = en && st_q.have;
        out_wide   = st_q.wide;
        half       = st_q.upper ? st_q.word[2*W_HALF-1:W_HALF] : st_q.word[W_HALF-1:0];
        out_data   = st_q.wide ? st_q.word[W_SAMPLE-1:0] : {half, {PAD{1'b0}}};

        st_d = st_q;
        if (!en) begin
            st_d.have  = 1'b0;
            st_d.upper = 1'b0;
        end else if (take) begin
            st_d.have  = 1'b1;
            st_d.word  = in_data;
            st_d.wide  = !narrow;
            st_d.upper = 1'b0;
        end else if (st_q.have && out_ready) begin
            if (last_piece) begin
                st_d.have  = 1'b0;
                st_d.upper = 1'b0;
            end else begin
                st_d.upper = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{have: 1'b0, wide: 1'b1, upper: 1'b0, word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a disabled lane neither takes words nor offers samples
    p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!in_ready && !out_valid));
    // R9: a stalled sample is held until taken or the lane is disabled
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (!en || (out_valid && $stable(out_data) && $stable(out_wide))));
    // R5: narrow samples carry zero padding in the low bits
    p_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_data[PAD-1:0] == '0));
    // R8: a new word only enters when the held one has been consumed
    p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && out_valid) |-> out_ready);
endmodule

// File: rtl/dac_unpack_top.sv
module dac_unpack_top
    import dac_unpack_pkg::*;
#(
    parameter int          NUM_CH    = 2,
    parameter int          AW        = 20,
    parameter logic [19:0] CTRL_ADDR = 20'h40080
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [AW-1:0]                reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic [NUM_CH-1:0]            in_valid,
    input  logic [NUM_CH*WORD_W-1:0]     in_data,
    output logic [NUM_CH-1:0]            in_ready,
    output logic [NUM_CH-1:0]            out_valid,
    output logic [NUM_CH*SAMPLE_W-1:0]   out_data,
    output logic [NUM_CH-1:0]            out_wide,
    input  logic [NUM_CH-1:0]            out_ready
);
    logic [NUM_CH-1:0] ch_en;
    logic [NUM_CH-1:0] ch_narrow;

    dac_ctl_regs #(
        .NUM_CH   (NUM_CH),
        .AW       (AW),
        .DW       (32),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ch_en    (ch_en),
        .ch_narrow(ch_narrow)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        dac_lane #(
            .W_WORD  (WORD_W),
            .W_SAMPLE(SAMPLE_W),
            .W_HALF  (HALF_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[c]),
            .narrow   (ch_narrow[c]),
            .in_valid (in_valid[c]),
            .in_data  (in_data[c*WORD_W +: WORD_W]),
            .in_ready (in_ready[c]),
            .out_valid(out_valid[c]),
            .out_data (out_data[c*SAMPLE_W +: SAMPLE_W]),
            .out_wide (out_wide[c]),
            .out_ready(out_ready[c])
        );
    end
endmodule

// File: tb/tb_dac_unpack_top.sv
`timescale 1ns/1ps
module tb_dac_unpack_top;
    localparam logic [19:0] CTRL = 20'h40080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [19:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  in_valid = '0;
    logic [63:0] in_data = '0;
    logic [1:0]  in_ready;
    logic [1:0]  out_valid;
    logic [39:0] out_data;
    logic [1:0]  out_wide;
    logic [1:0]  out_ready = '0;

    dac_unpack_top dut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string tag = "R1";
    logic [1:0] en_s = '0, nar_s = '0;
    logic [1:0] hold_p = '0;
    logic [20:0] prev_s [2];
    logic [20:0] expq [2][$];

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [20:0] smp(input bit wide, input logic [15:0] h, input logic [19:0] w);
        return wide ? {1'b1, w} : {1'b0, h, 4'b0000};
    endfunction

    task automatic cycle(input bit wr, input logic [19:0] a, input logic [31:0] d, input int pv, input int pr);
        @(negedge clk);
        reg_we = wr; reg_addr = a; reg_wdata = d;
        for (int c = 0; c < 2; c++) begin
            in_valid[c]  = ($urandom % 100) < pv;
            out_ready[c] = ($urandom % 100) < pr;
            in_data[c*32 +: 32] = $urandom;
        end
        #1;
        for (int c = 0; c < 2; c++) begin
            logic [20:0] cur;
            cur = {out_wide[c], out_data[c*20 +: 20]};
            if (!en_s[c])
                chk(!in_ready[c] && !out_valid[c], "R6", {30'd0, in_ready[c], out_valid[c]}, 0);
            if (hold_p[c] && en_s[c])
                chk(out_valid[c] && cur == prev_s[c], "R9", {11'd0, cur}, {11'd0, prev_s[c]});
            if (out_valid[c] && out_ready[c]) begin
                if (expq[c].size() == 0) begin
                    chk(1'b0, tag, {11'd0, cur}, 32'hDEAD);
                end else begin
                    logic [20:0] e;
                    e = expq[c].pop_front();
                    chk(cur == e, e[20] ? {tag, "/R3"} : {tag, "/R4/R5"}, {11'd0, cur}, {11'd0, e});
                end
            end
            if (in_valid[c] && in_ready[c]) begin
                logic [31:0] w;
                w = in_data[c*32 +: 32];
                if (nar_s[c]) begin
                    expq[c].push_back(smp(1'b0, w[15:0], '0));
                    expq[c].push_back(smp(1'b0, w[31:16], '0));
                end else begin
                    expq[c].push_back(smp(1'b1, '0, w[19:0]));
                end
            end
            hold_p[c] = out_valid[c] && !out_ready[c];
            prev_s[c] = cur;
        end
        if (wr && a == CTRL) begin
            for (int c = 0; c < 2; c++) begin
                if (!d[2*c]) expq[c].delete();
                en_s[c]  = d[2*c];
                nar_s[c] = d[2*c+1];
            end
        end
        @(posedge clk);
    endtask

    task automatic run(input int n, input int pv, input int pr);
        for (int i = 0; i < n; i++) cycle(1'b0, 20'h0, 32'h0, pv, pr);
    endtask

    task automatic rd(input logic [19:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a; in_valid = '0; out_ready = '0;
        #1;
        chk(reg_rdata == e, req, reg_rdata, e);
    endtask

    task automatic drain();
        for (int i = 0; i < 20; i++) cycle(1'b0, 20'h0, 32'h0, 0, 100);
        for (int c = 0; c < 2; c++)
            chk(expq[c].size() == 0, {tag, " drain"}, expq[c].size(), 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1357);
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        reg_addr = CTRL; in_valid = 2'b11; out_ready = 2'b11;
        #1;
        chk(reg_rdata == 0, "R1 ctrl", reg_rdata, 0);
        chk(in_ready == 0 && out_valid == 0, "R1 hs", {28'd0, in_ready, out_valid}, 0);
        rst_n = 1'b1;
        rd(CTRL, 0, "R1");
        // R2: register decode
        tag = "R2";
        cycle(1'b1, 20'h40084, 32'hFFFF_FFFF, 0, 0);
        rd(CTRL, 0, "R2 foreign write");
        rd(20'h40084, 0, "R2 foreign read");
        cycle(1'b1, CTRL, 32'hFFFF_FFF6, 0, 0);
        rd(CTRL, 32'h6, "R2 width");
        cycle(1'b1, CTRL, 32'h0, 0, 0);
        // R3: both 20-bit
        tag = "R3";
        cycle(1'b1, CTRL, 32'h5, 0, 0);
        run(400, 70, 70);
        drain();
        // R4: both 16-bit
        tag = "R4";
        cycle(1'b1, CTRL, 32'hF, 0, 0);
        run(400, 70, 60);
        drain();
        // R10: mixed widths, then one channel off
        tag = "R10";
        cycle(1'b1, CTRL, 32'h7, 0, 0);
        run(400, 80, 50);
        cycle(1'b1, CTRL, 32'h3, 0, 0);
        run(200, 80, 50);
        drain();
        // R8: width change while a narrow word is held
        tag = "R8";
        cycle(1'b1, CTRL, 32'hF, 0, 0);
        run(3, 100, 0);
        cycle(1'b1, CTRL, 32'h5, 0, 0);
        run(6, 100, 0);
        run(40, 100, 100);
        drain();
        // R7: disable with a half-used word, then re-enable
        tag = "R7";
        cycle(1'b1, CTRL, 32'hF, 100, 0);
        run(2, 100, 100);
        run(1, 0, 0);
        cycle(1'b1, CTRL, 32'h0, 0, 0);
        run(3, 100, 100);
        cycle(1'b1, CTRL, 32'hF, 0, 0);
        run(60, 90, 90);
        drain();
        // R8: random configuration churn
        tag = "R8";
        for (int k = 0; k < 80; k++) begin
            cycle(1'b1, CTRL, {28'd0, 4'($urandom)}, 60, 60);
            run(37, 60, 60);
        end
        cycle(1'b1, CTRL, 32'h0, 0, 0);
        run(4, 50, 50);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule